// File: doc/BRIEF.md
# Code-Block Weighted Uplink/Downlink Arbiter

This block decides which of two code-block streams, uplink (UL) and downlink (DL), may use a shared host data path next. Each stream raises a request while it has a code block waiting. The arbiter answers with a one-hot grant. The granted side moves one whole code block and then pulses `cb_done`. The grant is held until that pulse, is released on the following cycle, and a fresh decision is made on the cycle after that.

When `congested` is low, the arbiter takes turns between the requesting directions and ignores the weights. When `congested` is high, each direction gets a per-round credit of `CB_PER_UNIT` × weight code blocks, with `CB_PER_UNIT` = 3 by default. Credit is counted in whole blocks, whatever their length. While both directions hold credit they take turns. A direction with credit left continues alone once the other is spent. A new round reloads both credits once neither requesting side has any credit left.

A direction that is not requesting loses whatever credit it still has, so it never holds up the other side. A direction with weight zero is served only while the other direction is idle. For example, a 12:1 block-rate split corresponds to weights 12 and 1, which gives 36 UL and 3 DL blocks per round.

Top module: `cb_weight_arb`

## Requirements
- R1: `grant` is one-hot or zero at all times. Bit 0 is UL and bit 1 is DL. It is zero after reset.
- R2: A grant is issued only to a direction whose request was high on the deciding cycle. No grant is issued while neither direction requests.
- R3: A grant stays unchanged until `cb_done` is high. It drops to zero on the cycle after `cb_done` is sampled.
- R4: With `congested` low, simultaneous requests alternate UL/DL, regardless of the weights. After reset, UL goes first. A lone requester is granted every time.
- R5: With `congested` high, a round gives each requesting direction 3 × its weight grants. Credit is charged once per completed block.
- R6: With `congested` high, both directions alternate while both hold credit. The direction with credit left then takes every grant. When both are spent, a new round reloads the credits and the alternation continues from the last winner.
- R7: With `congested` high, a direction of weight zero gets no grant while the other direction, of non-zero weight, is requesting. It is granted once the other direction is idle.
- R8: A direction that is not requesting at a decision forfeits its credit. If the remaining requester has no credit, a new round starts at once and that requester is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ul_req | input | 1 | Uplink has a code block waiting |
| dl_req | input | 1 | Downlink has a code block waiting |
| congested | input | 1 | Shared path congested; enables weighting |
| ul_weight | input | WEIGHT_W | Uplink weight, in units of CB_PER_UNIT blocks |
| dl_weight | input | WEIGHT_W | Downlink weight, in units of CB_PER_UNIT blocks |
| cb_done | input | 1 | Granted side finished its code block |
| grant | output | 2 | One-hot grant, bit 0 UL, bit 1 DL |

## Verification
The embedded assertions check the following on every cycle:
- the grant is one-hot or zero;
- a grant only goes to a requester, and none is issued while neither side requests;
- a grant stays stable until the done pulse;
- the credit counters stay bounded;
- a zero-weight side is never chosen over a weighted requester under congestion.

The exact grant order cannot be seen by a single-cycle property, so only the directed scenarios show it. This covers the round lengths of 3 × weight, the alternation and its continuation across rounds, the 36:3 split for weights 12 and 1, forfeiture, and the switch to plain alternation when congestion is low.

// File: rtl/cb_weight_arb.sv
module cb_weight_arb #(
  parameter int WEIGHT_W    = 8,
  parameter int CB_PER_UNIT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ul_req,
  input  logic                dl_req,
  input  logic                congested,
  input  logic [WEIGHT_W-1:0] ul_weight,
  input  logic [WEIGHT_W-1:0] dl_weight,
  input  logic                cb_done,
  output logic [1:0]          grant
);
  localparam int MAX_CRED = CB_PER_UNIT * ((1 << WEIGHT_W) - 1);
  localparam int CRED_W   = $clog2(MAX_CRED + 1);

  logic              last_ul;
  logic [CRED_W-1:0] ul_cred, dl_cred;
  logic [CRED_W-1:0] avail_u, avail_d, full_u, full_d, eff_u, eff_d;
  logic              arb, reload, pick_ul;

  assign arb     = (grant == 2'b00) && (ul_req || dl_req);
  assign avail_u = ul_req ? ul_cred : '0;
  assign avail_d = dl_req ? dl_cred : '0;
  assign full_u  = CRED_W'(ul_weight) * CRED_W'(CB_PER_UNIT);
  assign full_d  = CRED_W'(dl_weight) * CRED_W'(CB_PER_UNIT);
  assign reload  = (avail_u == '0) && (avail_d == '0);
  assign eff_u   = reload ? (ul_req ? full_u : '0) : avail_u;
  assign eff_d   = reload ? (dl_req ? full_d : '0) : avail_d;

  always_comb begin
    if (!congested || (eff_u == '0 && eff_d == '0))
      pick_ul = (ul_req && dl_req) ? !last_ul : ul_req;
    else if (eff_u != '0 && eff_d != '0)
      pick_ul = !last_ul;
    else
      pick_ul = (eff_u != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant   <= 2'b00;
      last_ul <= 1'b0;
      ul_cred <= '0;
      dl_cred <= '0;
    end else if (arb) begin
      grant   <= pick_ul ? 2'b01 : 2'b10;
      last_ul <= pick_ul;
      ul_cred <= congested ? eff_u : '0;
      dl_cred <= congested ? eff_d : '0;
    end else if (grant != 2'b00 && cb_done) begin
      grant <= 2'b00;
      if (grant[0] && ul_cred != '0) ul_cred <= ul_cred - 1'b1;
      if (grant[1] && dl_cred != '0) dl_cred <= dl_cred - 1'b1;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00) |=> ((!grant[0] || $past(ul_req)) && (!grant[1] || $past(dl_req))));

  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && !ul_req && !dl_req) |=> (grant == 2'b00));

  assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && !cb_done) |=> $stable(grant));

  assert_release_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && cb_done) |=> (grant == 2'b00));

  assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_cred <= CRED_W'(MAX_CRED)) && (dl_cred <= CRED_W'(MAX_CRED)));

  assert_zero_weight_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b00 && congested && ul_req && dl_req && ul_weight == '0 &&
     dl_weight != '0 && ul_cred == '0) |=> (grant == 2'b10));
endmodule

// File: tb/sim_cb_weight_arb.sv
module sim_cb_weight_arb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ul_req = 1'b0, dl_req = 1'b0, congested = 1'b0, cb_done = 1'b0;
  logic [7:0] ul_weight = '0, dl_weight = '0;
  logic [1:0] grant;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  cb_weight_arb u0 (
    .clk(clk), .rst_n(rst_n), .ul_req(ul_req), .dl_req(dl_req),
    .congested(congested), .ul_weight(ul_weight), .dl_weight(dl_weight),
    .cb_done(cb_done), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    ul_req = 0; dl_req = 0; cb_done = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // waits for a grant, returns 1 for UL and 0 for DL, then completes the block
  task automatic get_grant(input string tag, output bit is_ul);
    int waited = 0;
    is_ul = 0;
    while (grant == 2'b00 && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    check(grant == 2'b01 || grant == 2'b10, {tag, " one-hot grant R1"}, grant, 1);
    is_ul = grant[0];
    cb_done = 1;
    @(negedge clk);
    cb_done = 0;
    check(grant == 2'b00, {tag, " release after done R3"}, grant, 0);
  endtask

  task automatic run_seq(input string tag, input int n, input logic [63:0] exp_ul);
    bit u;
    for (int i = 0; i < n; i++) begin
      get_grant(tag, u);
      check(u == exp_ul[i], {tag, " grant order"}, u, exp_ul[i]);
    end
  endtask

  task automatic t_reset_hold();
    do_reset();
    check(grant == 2'b00, "reset state R1", grant, 0);
    congested = 0;
    repeat (4) @(negedge clk);
    check(grant == 2'b00, "no request no grant R2", grant, 0);
    dl_req = 1;
    @(negedge clk);
    check(grant == 2'b10, "lone DL granted R2", grant, 2);
    repeat (5) @(negedge clk);
    check(grant == 2'b10, "grant held without done R3", grant, 2);
    cb_done = 1;
    @(negedge clk);
    cb_done = 0;
    dl_req = 0;
    check(grant == 2'b00, "grant dropped after done R3", grant, 0);
    repeat (3) @(negedge clk);
    check(grant == 2'b00, "no grant after request drop R2", grant, 0);
  endtask

  task automatic t_uncongested();
    do_reset();
    congested = 0; ul_weight = 5; dl_weight = 0;
    ul_req = 1; dl_req = 1;
    run_seq("R4 alternate", 6, 64'b010101);
    ul_req = 0;
    run_seq("R4 lone DL", 3, 64'b000);
    dl_req = 0;
  endtask

  task automatic t_rounds();
    do_reset();
    congested = 1; ul_weight = 2; dl_weight = 1;
    ul_req = 1; dl_req = 1;
    // round 1: U D U D U D U U U ; round 2: D U D U D U U U U (bit0 = first)
    run_seq("R5 R6 rounds", 18, 64'b111101010_111010101);
    ul_req = 0; dl_req = 0;
  endtask

  task automatic t_ratio();
    bit u;
    int nu = 0, nd = 0;
    do_reset();
    congested = 1; ul_weight = 12; dl_weight = 1;
    ul_req = 1; dl_req = 1;
    for (int i = 0; i < 39; i++) begin
      get_grant("R5 ratio", u);
      if (u) nu++; else nd++;
    end
    check(nu == 36, "R5 UL blocks per round", nu, 36);
    check(nd == 3, "R5 DL blocks per round", nd, 3);
    ul_req = 0; dl_req = 0;
  endtask

  task automatic t_zero_weight();
    do_reset();
    congested = 1; ul_weight = 0; dl_weight = 2;
    ul_req = 1; dl_req = 1;
    run_seq("R7 zero weight starved", 12, 64'h0);
    dl_req = 0;
    run_seq("R7 zero weight when other idle", 2, 64'b11);
    ul_req = 0;
  endtask

  task automatic t_forfeit();
    bit u;
    do_reset();
    congested = 1; ul_weight = 1; dl_weight = 4;
    ul_req = 1; dl_req = 1;
    run_seq("R8 lead-in", 6, 64'b010101);
    dl_req = 0;
    get_grant("R8 forfeit", u);
    check(u == 1'b1, "R8 UL granted after DL forfeits", u, 1);
    ul_req = 0;
  endtask

  initial begin
    t_reset_hold();
    t_uncongested();
    t_rounds();
    t_ratio();
    t_zero_weight();
    t_forfeit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule